// File: doc/BRIEF.md
# Microcontroller-to-IDE PIO Access Bridge

This bridge connects the external data bus of an 8-bit microcontroller to a drive PIO cycle engine. A write into the drive register window starts a drive write. A write to the first address of the window is the 16-bit data port: the bridge joins the written byte with a high-byte holding register, which software loads beforehand. A write to any other window address sends a single byte.

Reads take two phases. The first bus read returns filler data and only starts the drive cycle. When the engine reports completion, the bridge stores the drive data in a low-byte register and, for data-port reads, a high-byte register. Software then reads both through the special-function register bus.

A completion bit reports when the bridge is idle. A sticky error bit records any access attempted while a cycle is still in flight; such an access is dropped. Each finished cycle sets an interrupt status bit. The interrupt output is that status gated by an enable bit.

Top module: `ide_pio_bridge`

## Requirements
- R1: After reset the control register (SFR 0xDD) reads 0x01 (bit0 complete=1, bit1 error=0, bit2 interrupt enable=0). The interrupt status register (SFR 0xDE) reads 0x00. The low-byte (0xDC) and high-byte (0xDB) registers read 0x00, and pioReq and irq are low.
- R2: A bus write to 0x31F0 while complete drives pioReq high for exactly one cycle, starting the cycle after the write strobe. In that cycle pioWrite=1, pioWide=1, pioReg=0, and pioWrData = {high-byte register, written byte}.
- R3: A bus write to 0x31F1..0x31F7 while complete launches the same way with pioWide=0, pioReg equal to address bits [2:0], and pioWrData = {8'h00, written byte}. The high-byte register is left unchanged.
- R4: A bus read inside the window 0x31F0..0x31F7 returns 0xFF on xRdData in the same cycle. It launches a drive read with pioWrite=0 and pioWide set only for 0x31F0.
- R5: The complete bit (control bit0) clears in the cycle after a launch. It sets again in the cycle after pioDone is seen while a cycle is outstanding.
- R6: When a 16-bit read completes, pioRdData[7:0] is loaded into the low-byte register and pioRdData[15:8] into the high-byte register.
- R7: When an 8-bit read completes, only the low-byte register is loaded; the high-byte register keeps its value.
- R8: A window access made while complete=0 produces no pioReq and sets control bit1 (error). The error bit stays set until software writes 1 to bit1 of the control register.
- R9: Each completion sets interrupt status bit0. irq equals status bit0 AND enable bit2. Writing 1 to status bit0 clears it.
- R10: Accesses outside the window launch nothing and return 0x00 on xRdData. A pioDone while no cycle is outstanding changes neither the data registers nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xAddr | input | 16 | External data bus address |
| xWrData | input | 8 | External bus write data |
| xWr | input | 1 | External bus write strobe, one cycle |
| xRd | input | 1 | External bus read strobe, one cycle |
| xRdData | output | 8 | External bus read data (filler) |
| sfrAddr | input | 8 | Special-function register address |
| sfrWrData | input | 8 | SFR write data |
| sfrWr | input | 1 | SFR write strobe |
| sfrRdData | output | 8 | SFR read data, combinational from sfrAddr |
| pioReq | output | 1 | One-cycle request to the PIO cycle engine |
| pioWrite | output | 1 | Request is a drive write |
| pioWide | output | 1 | Request is a 16-bit data-port transfer |
| pioReg | output | 3 | Drive register index |
| pioWrData | output | 16 | Drive write word |
| pioDone | input | 1 | Engine reports the drive cycle finished |
| pioRdData | input | 16 | Drive read word, valid with pioDone |
| irq | output | 1 | Interrupt request |

## Verification
A bridge stuck busy shows up at once: the control register reads complete=0, the next vector produces no request, and a spurious error bit appears. A missed or doubled request is visible on pioReq in the cycle after the strobe. A wrong capture path, such as a narrow read overwriting the high byte, shows in the holding registers read back one cycle after pioDone. Interrupt gating faults appear on irq in the cycle after the enable or status write.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int REG_BITS = 3;

  typedef enum logic [1:0] {PIO_IDLE, PIO_ISSUE, PIO_WAIT} pioState_t;

  typedef struct packed {
    logic                launch;
    logic                launchRead;
    logic                launchWide;
    logic [REG_BITS-1:0] launchReg;
    logic                finish;
    logic                refuse;
  } pioStrobe_t;
endpackage

// File: rtl/ide_pio_ctrl.sv
module ide_pio_ctrl
  import ide_pio_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] DRIVE_BASE = 16'h31F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] xAddr,
  input  logic              xWr,
  input  logic              xRd,
  input  logic              pioDone,
  output pioStrobe_t        st,
  output logic              driveHit,
  output logic              pioReq,
  output logic              pioComplete
);
  localparam logic [ADDR_W-1:0] BASE = DRIVE_BASE[ADDR_W-1:0];

  pioState_t state, stateNext;
  logic      access;

  assign driveHit    = (xAddr[ADDR_W-1:REG_BITS] == BASE[ADDR_W-1:REG_BITS]);
  assign access      = driveHit && (xWr || xRd);
  assign pioReq      = (state == PIO_ISSUE);
  assign pioComplete = (state == PIO_IDLE);

  always_comb begin
    st            = '0;
    st.launch     = access && (state == PIO_IDLE);
    st.launchRead = !xWr;
    st.launchWide = (xAddr[REG_BITS-1:0] == '0);
    st.launchReg  = xAddr[REG_BITS-1:0];
    st.finish     = (state == PIO_WAIT) && pioDone;
    st.refuse     = access && (state != PIO_IDLE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      PIO_IDLE:  if (st.launch) stateNext = PIO_ISSUE;
      PIO_ISSUE: stateNext = PIO_WAIT;
      PIO_WAIT:  if (pioDone) stateNext = PIO_IDLE;
      default:   stateNext = PIO_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PIO_IDLE;
    else       state <= stateNext;
  end

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pioReq |=> !pioReq);
  // R5
  launch_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (access && pioComplete) |=> (pioReq && !pioComplete));
  // R8
  busy_norq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (access && !pioComplete) |=> !pioReq);
  // R5
  done_complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pioComplete && !pioReq && pioDone) |=> pioComplete);
endmodule

// File: rtl/ide_pio_datapath.sv
module ide_pio_datapath
  import ide_pio_pkg::*;
#(
  parameter int         BYTE_W   = 8,
  parameter int         SFR_W    = 8,
  parameter logic [7:0] SFR_HI   = 8'hDB,
  parameter logic [7:0] SFR_LO   = 8'hDC,
  parameter logic [7:0] SFR_CTRL = 8'hDD,
  parameter logic [7:0] SFR_IST  = 8'hDE
) (
  input  logic                clk,
  input  logic                rstN,
  input  pioStrobe_t          st,
  input  logic                driveHit,
  input  logic                pioComplete,
  input  logic                xRd,
  input  logic [BYTE_W-1:0]   xWrData,
  output logic [BYTE_W-1:0]   xRdData,
  input  logic [SFR_W-1:0]    sfrAddr,
  input  logic [BYTE_W-1:0]   sfrWrData,
  input  logic                sfrWr,
  output logic [BYTE_W-1:0]   sfrRdData,
  output logic                pioWrite,
  output logic                pioWide,
  output logic [REG_BITS-1:0] pioReg,
  output logic [2*BYTE_W-1:0] pioWrData,
  input  logic [2*BYTE_W-1:0] pioRdData,
  output logic                irq
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int BIT_COMPLETE = 0;
  localparam int BIT_ERROR    = 1;
  localparam int BIT_INTEN    = 2;
  localparam int BIT_INTST    = 0;

  logic [BYTE_W-1:0]   hiReg, loReg;
  logic                opRead, opWide;
  logic [REG_BITS-1:0] opReg;
  logic [WORD_W-1:0]   opWord;
  logic                errSticky, intStatus, intEn;
  logic                hiWrite, ctrlWrite, istWrite;

  assign hiWrite   = sfrWr && (sfrAddr == SFR_W'(SFR_HI));
  assign ctrlWrite = sfrWr && (sfrAddr == SFR_W'(SFR_CTRL));
  assign istWrite  = sfrWr && (sfrAddr == SFR_W'(SFR_IST));

  // launch latch: operation description held for the engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opRead <= 1'b0;
      opWide <= 1'b0;
      opReg  <= '0;
      opWord <= '0;
    end else if (st.launch) begin
      opRead <= st.launchRead;
      opWide <= st.launchWide;
      opReg  <= st.launchReg;
      opWord <= st.launchWide ? {hiReg, xWrData} : {{BYTE_W{1'b0}}, xWrData};
    end
  end

  // holding registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0;
      loReg <= '0;
    end else begin
      if (st.finish && opRead) begin
        loReg <= pioRdData[BYTE_W-1:0];
        if (opWide) hiReg <= pioRdData[WORD_W-1:BYTE_W];
        else if (hiWrite) hiReg <= sfrWrData;
      end else if (hiWrite) begin
        hiReg <= sfrWrData;
      end
    end
  end

  // error, interrupt status and enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errSticky <= 1'b0;
      intStatus <= 1'b0;
      intEn     <= 1'b0;
    end else begin
      if (st.refuse) errSticky <= 1'b1;
      else if (ctrlWrite && sfrWrData[BIT_ERROR]) errSticky <= 1'b0;
      if (st.finish) intStatus <= 1'b1;
      else if (istWrite && sfrWrData[BIT_INTST]) intStatus <= 1'b0;
      if (ctrlWrite) intEn <= sfrWrData[BIT_INTEN];
    end
  end

  always_comb begin
    sfrRdData = '0;
    if (sfrAddr == SFR_W'(SFR_HI)) sfrRdData = hiReg;
    else if (sfrAddr == SFR_W'(SFR_LO)) sfrRdData = loReg;
    else if (sfrAddr == SFR_W'(SFR_CTRL)) begin
      sfrRdData[BIT_COMPLETE] = pioComplete;
      sfrRdData[BIT_ERROR]    = errSticky;
      sfrRdData[BIT_INTEN]    = intEn;
    end else if (sfrAddr == SFR_W'(SFR_IST)) sfrRdData[BIT_INTST] = intStatus;
  end

  assign xRdData   = (xRd && driveHit) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
  assign pioWrite  = !opRead;
  assign pioWide   = opWide;
  assign pioReg    = opReg;
  assign pioWrData = opWord;
  assign irq       = intStatus && intEn;

  // R7
  narrow_hi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.finish && opRead && !opWide && !hiWrite) |=> $stable(hiReg));
  // R6
  wide_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.finish && opRead && opWide) |=> (hiReg == $past(pioRdData[WORD_W-1:BYTE_W])));
  // R8
  refuse_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.refuse |=> errSticky);
  // R9
  status_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.finish |=> intStatus);
endmodule

// File: rtl/ide_pio_bridge.sv
module ide_pio_bridge
  import ide_pio_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          BYTE_W     = 8,
  parameter int          SFR_W      = 8,
  parameter logic [15:0] DRIVE_BASE = 16'h31F0,
  parameter logic [7:0]  SFR_HI     = 8'hDB,
  parameter logic [7:0]  SFR_LO     = 8'hDC,
  parameter logic [7:0]  SFR_CTRL   = 8'hDD,
  parameter logic [7:0]  SFR_IST    = 8'hDE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   xAddr,
  input  logic [BYTE_W-1:0]   xWrData,
  input  logic                xWr,
  input  logic                xRd,
  output logic [BYTE_W-1:0]   xRdData,
  input  logic [SFR_W-1:0]    sfrAddr,
  input  logic [BYTE_W-1:0]   sfrWrData,
  input  logic                sfrWr,
  output logic [BYTE_W-1:0]   sfrRdData,
  output logic                pioReq,
  output logic                pioWrite,
  output logic                pioWide,
  output logic [REG_BITS-1:0] pioReg,
  output logic [2*BYTE_W-1:0] pioWrData,
  input  logic                pioDone,
  input  logic [2*BYTE_W-1:0] pioRdData,
  output logic                irq
);
  pioStrobe_t st;
  logic       driveHit;
  logic       pioComplete;

  ide_pio_ctrl #(.ADDR_W(ADDR_W), .DRIVE_BASE(DRIVE_BASE)) ctrl (
    .clk(clk), .rstN(rstN), .xAddr(xAddr), .xWr(xWr), .xRd(xRd),
    .pioDone(pioDone), .st(st), .driveHit(driveHit),
    .pioReq(pioReq), .pioComplete(pioComplete)
  );

  ide_pio_datapath #(
    .BYTE_W(BYTE_W), .SFR_W(SFR_W), .SFR_HI(SFR_HI), .SFR_LO(SFR_LO),
    .SFR_CTRL(SFR_CTRL), .SFR_IST(SFR_IST)
  ) dpath (
    .clk(clk), .rstN(rstN), .st(st), .driveHit(driveHit),
    .pioComplete(pioComplete), .xRd(xRd), .xWrData(xWrData), .xRdData(xRdData),
    .sfrAddr(sfrAddr), .sfrWrData(sfrWrData), .sfrWr(sfrWr), .sfrRdData(sfrRdData),
    .pioWrite(pioWrite), .pioWide(pioWide), .pioReg(pioReg), .pioWrData(pioWrData),
    .pioRdData(pioRdData), .irq(irq)
  );
endmodule

// File: tb/ide_pio_bridge_test.sv
`timescale 1ns/1ps
module ide_pio_bridge_test;
  localparam logic [7:0] A_HI = 8'hDB, A_LO = 8'hDC, A_CTRL = 8'hDD, A_IST = 8'hDE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] xAddr = '0;
  logic [7:0]  xWrData = '0;
  logic        xWr = 1'b0, xRd = 1'b0;
  logic [7:0]  xRdData;
  logic [7:0]  sfrAddr = '0, sfrWrData = '0;
  logic        sfrWr = 1'b0;
  logic [7:0]  sfrRdData;
  logic        pioReq, pioWrite, pioWide, irq;
  logic [2:0]  pioReg;
  logic [15:0] pioWrData;
  logic        pioDone = 1'b0;
  logic [15:0] pioRdData = '0;

  int tests = 0, fails = 0, cycles = 0;

  ide_pio_bridge uut (
    .clk(clk), .rstN(rstN), .xAddr(xAddr), .xWrData(xWrData), .xWr(xWr), .xRd(xRd),
    .xRdData(xRdData), .sfrAddr(sfrAddr), .sfrWrData(sfrWrData), .sfrWr(sfrWr),
    .sfrRdData(sfrRdData), .pioReq(pioReq), .pioWrite(pioWrite), .pioWide(pioWide),
    .pioReg(pioReg), .pioWrData(pioWrData), .pioDone(pioDone), .pioRdData(pioRdData),
    .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: all requirements, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic readSfr(input logic [7:0] a, output logic [7:0] d);
    sfrAddr = a;
    #0.5;
    d = sfrRdData;
  endtask

  task automatic writeSfr(input logic [7:0] a, input logic [7:0] d);
    sfrAddr = a; sfrWrData = d; sfrWr = 1'b1;
    @(negedge clk);
    sfrWr = 1'b0;
  endtask

  task automatic pulseDone(input logic [15:0] w);
    pioDone = 1'b1; pioRdData = w;
    @(negedge clk);
    pioDone = 1'b0;
  endtask

  typedef struct packed {
    logic        rd;
    logic [15:0] addr;
    logic [7:0]  wb;
    logic        pre;
    logic [7:0]  preHi;
    logic [15:0] ret;
    logic        wide;
    logic [2:0]  regIx;
    logic [15:0] word;
    logic [7:0]  lo;
    logic [7:0]  hi;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h31F0, 8'h34, 1'b1, 8'h12, 16'h0000, 1'b1, 3'd0, 16'h1234, 8'h00, 8'h12},
    '{1'b0, 16'h31F3, 8'h5A, 1'b0, 8'h00, 16'h0000, 1'b0, 3'd3, 16'h005A, 8'h00, 8'h12},
    '{1'b1, 16'h31F0, 8'h00, 1'b0, 8'h00, 16'hBEEF, 1'b1, 3'd0, 16'h0000, 8'hEF, 8'hBE},
    '{1'b1, 16'h31F7, 8'h00, 1'b0, 8'h00, 16'h1177, 1'b0, 3'd7, 16'h0000, 8'h77, 8'hBE},
    '{1'b0, 16'h31F0, 8'h0F, 1'b1, 8'hA5, 16'h0000, 1'b1, 3'd0, 16'hA50F, 8'h77, 8'hA5},
    '{1'b1, 16'h31F2, 8'h00, 1'b0, 8'h00, 16'hFF00, 1'b0, 3'd2, 16'h0000, 8'h00, 8'hA5},
    '{1'b0, 16'h31F7, 8'hC3, 1'b0, 8'h00, 16'h0000, 1'b0, 3'd7, 16'h00C3, 8'h00, 8'hA5},
    '{1'b1, 16'h31F0, 8'h00, 1'b0, 8'h00, 16'h8001, 1'b1, 3'd0, 16'h0000, 8'h01, 8'h80}
  };

  initial begin
    logic [7:0] d;
    string tag;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readSfr(A_CTRL, d); check("R1", "ctrl", {8'h0, d}, 16'h0001);
    readSfr(A_IST, d);  check("R1", "intStatus", {8'h0, d}, 16'h0000);
    readSfr(A_LO, d);   check("R1", "lo", {8'h0, d}, 16'h0000);
    readSfr(A_HI, d);   check("R1", "hi", {8'h0, d}, 16'h0000);
    check("R1", "pioReq", {15'h0, pioReq}, 16'h0000);
    check("R1", "irq", {15'h0, irq}, 16'h0000);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      tag = v.rd ? (v.wide ? "R6" : "R7") : (v.wide ? "R2" : "R3");
      if (v.pre) writeSfr(A_HI, v.preHi);
      xAddr = v.addr;
      if (v.rd) xRd = 1'b1;
      else begin xWr = 1'b1; xWrData = v.wb; end
      #0.5;
      if (v.rd) check("R4", "xRdData filler", {8'h0, xRdData}, 16'h00FF);
      @(negedge clk);
      xRd = 1'b0; xWr = 1'b0;
      check(tag, "pioReq", {15'h0, pioReq}, 16'h0001);
      check(v.rd ? "R4" : tag, "pioWrite", {15'h0, pioWrite}, {15'h0, !v.rd});
      check(tag, "pioWide", {15'h0, pioWide}, {15'h0, v.wide});
      check(tag, "pioReg", {13'h0, pioReg}, {13'h0, v.regIx});
      if (!v.rd) check(tag, "pioWrData", pioWrData, v.word);
      readSfr(A_CTRL, d); check("R5", "complete cleared", {15'h0, d[0]}, 16'h0000);
      @(negedge clk);
      check("R2", "pioReq one cycle", {15'h0, pioReq}, 16'h0000);
      @(negedge clk);
      pulseDone(v.ret);
      readSfr(A_CTRL, d); check("R5", "complete set", {15'h0, d[0]}, 16'h0001);
      readSfr(A_LO, d);   check(tag, "lo", {8'h0, d}, {8'h0, v.lo});
      readSfr(A_HI, d);   check(tag, "hi", {8'h0, d}, {8'h0, v.hi});
      @(negedge clk);
    end

    // R9 interrupt status, enable and clear
    readSfr(A_IST, d); check("R9", "status after completions", {8'h0, d}, 16'h0001);
    check("R9", "irq disabled", {15'h0, irq}, 16'h0000);
    writeSfr(A_CTRL, 8'h04);
    check("R9", "irq enabled", {15'h0, irq}, 16'h0001);
    writeSfr(A_IST, 8'h01);
    check("R9", "irq after W1C", {15'h0, irq}, 16'h0000);
    readSfr(A_IST, d); check("R9", "status after W1C", {8'h0, d}, 16'h0000);

    // R8 access while busy is dropped and flagged
    xAddr = 16'h31F1; xRd = 1'b1;
    @(negedge clk); xRd = 1'b0;
    @(negedge clk);
    xAddr = 16'h31F0; xWrData = 8'h66; xWr = 1'b1;
    @(negedge clk); xWr = 1'b0;
    check("R8", "no request while busy", {15'h0, pioReq}, 16'h0000);
    readSfr(A_CTRL, d); check("R8", "error set", {15'h0, d[1]}, 16'h0001);
    pulseDone(16'h0042);
    check("R8", "no late request", {15'h0, pioReq}, 16'h0000);
    readSfr(A_CTRL, d); check("R8", "error sticky", {15'h0, d[1]}, 16'h0001);
    check("R9", "irq on completion", {15'h0, irq}, 16'h0001);
    writeSfr(A_CTRL, 8'h06);
    readSfr(A_CTRL, d); check("R8", "error W1C keeps enable", {8'h0, d}, 16'h0005);
    writeSfr(A_IST, 8'h01);

    // R10 outside window and stray completion
    xAddr = 16'h31E8; xWrData = 8'h11; xWr = 1'b1;
    @(negedge clk); xWr = 1'b0;
    check("R10", "no request outside window", {15'h0, pioReq}, 16'h0000);
    readSfr(A_CTRL, d); check("R10", "still complete", {15'h0, d[0]}, 16'h0001);
    xAddr = 16'h3200; xRd = 1'b1;
    #0.5;
    check("R10", "xRdData outside", {8'h0, xRdData}, 16'h0000);
    @(negedge clk); xRd = 1'b0;
    check("R10", "no request on outside read", {15'h0, pioReq}, 16'h0000);
    pulseDone(16'h9999);
    readSfr(A_LO, d);  check("R10", "lo after stray done", {8'h0, d}, 16'h0042);
    readSfr(A_HI, d);  check("R10", "hi after stray done", {8'h0, d}, 16'h0080);
    readSfr(A_IST, d); check("R10", "status after stray done", {8'h0, d}, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule